// File: doc/BRIEF.md
# Remote Terminal Command Decoder

This block sits behind the serial bus decoder of a remote terminal on a command/response avionics data bus. The line decoder hands it each validated 16-bit command word with a one-cycle strobe, and then a strobe for every data word that follows. At reset the block captures the terminal's own five-bit address and its parity bit from the address pins. From then on it compares each command with that address or with the broadcast address, splits the command into its fields, sorts it into receive, transmit or mode command and judges whether it is legal. The subsystem gets a command-valid pulse, and on a data receive it also gets a header pulse when the first data word arrives. This lets the subsystem inspect both words and reject the message.

A rejected or illegal message still gets a status reply, but the message-error flag is raised so that the reply carries the error bit and the received data is discarded. The block measures the dead time before the status reply with a counter clocked at the terminal's 16 MHz clock. The count starts at the command strobe when no data follows and at the last data word otherwise. A short-response option pin cuts the delay from 12 µs to 4 µs, and it also turns subaddress 31 from a mode-command alias into an ordinary data subaddress. When all six address pins float high through their pull-ups, a store-released output is raised.

Top module: `rt_cmd_decoder`

## Requirements
- R1: The own address and its parity bit are taken from the pins only while rstN is low. Changing the pins afterwards does not alter which commands are accepted.
- R2: A captured address whose six bits (address plus parity) hold an even number of ones, or an address equal to 31, is not a valid own address. addrValid is then low and no non-broadcast command is accepted.
- R3: storeReleased goes high one clock after all five address pins and the parity pin read 1, and it drops one clock after any of them reads 0.
- R4: A command is accepted when its bits 15:11 equal the valid own address or equal 31. Bits 15:11 equal to 31 also set cmdBroadcast. Any other command gives no cmdValid and leaves the decoded field outputs unchanged.
- R5: Command layout: bit 10 is T/R (1 = transmit), bits 9:5 are the subaddress, bits 4:0 are the word count or mode code. Subaddress 0 is always a mode command. Subaddress 31 is a mode command when shortRespEn is 0 and a data subaddress when it is 1.
- R6: For data commands cmdWordCount shows bits 4:0 with 0 standing for 32. A receive expects that many data words. A mode command with T/R = 0 and code 16 or above expects one data word.
- R7: A mode command is legal only for codes 0–8, 16, 18 and 19 with T/R = 1, or codes 17, 20 and 21 with T/R = 0. Broadcast with code 2, 16, 18 or 19 is illegal, and so is a broadcast transmit on a data subaddress. An illegal command sets msgError.
- R8: msgRejectN low at the accepting command strobe, or at any clock while the message's data or response wait is in progress, sets msgError. msgError holds until the next accepted command.
- R9: cmdValid is a one-cycle pulse in the clock after an accepted command strobe. The decoded fields are updated at the same edge.
- R10: headerRcvd pulses for one cycle after the first data word of an accepted receive to a data subaddress, and for no other word.
- R11: respStart pulses exactly 12·CLK_MHZ clocks (shortRespEn = 0) or 4·CLK_MHZ clocks (shortRespEn = 1) after the command strobe when no data follows, or after the last data word's strobe. Illegal and rejected messages also get it.
- R12: A broadcast command never produces respStart and cancels any pending response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz terminal clock |
| rstN | input | 1 | Synchronous active-low reset; the address pins are captured while it is low |
| addrPins | input | 5 | Own address pins, bit 0 least significant |
| addrParPin | input | 1 | Own address parity pin (odd) |
| shortRespEn | input | 1 | Short-response option: 4 µs delay and subaddress 31 used for data |
| msgRejectN | input | 1 | Active-low message reject from the subsystem |
| cmdStrobe | input | 1 | One-cycle strobe of a validated command word |
| cmdWord | input | 16 | Command word, valid with cmdStrobe |
| dataStrobe | input | 1 | One-cycle strobe of a validated data word |
| addrValid | output | 1 | Captured own address has odd parity and is not 31 |
| storeReleased | output | 1 | All six address pins read high |
| cmdValid | output | 1 | Pulse: command accepted for this terminal |
| headerRcvd | output | 1 | Pulse: first data word (header) received |
| cmdIsTx | output | 1 | Last accepted command is a transmit |
| cmdIsMode | output | 1 | Last accepted command is a mode command |
| cmdBroadcast | output | 1 | Last accepted command was broadcast |
| cmdSubAddr | output | 5 | Subaddress field of the last accepted command |
| cmdCode | output | 5 | Raw word count / mode code field |
| cmdWordCount | output | 6 | Decoded word count 1–32, 0 for mode commands |
| msgError | output | 1 | Message-error status condition, data to be discarded |
| respStart | output | 1 | Pulse: start of the status reply |

## Verification
The assertions assume that the line decoder never raises cmdStrobe and dataStrobe in the same cycle, and that both stay low while rstN is low. They also assume that every strobe lasts exactly one clock. The stimulus keeps to this by driving each strobe for a single clock from the falling edge and leaving at least one idle clock between words. The address pins only change while reset is asserted, except in the scenarios that test pin changes on purpose. The short-response pin is held steady from a command until its response has started.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;

  localparam int FIELD_W  = 5;
  localparam int WORD_W   = 16;
  localparam int COUNT_W  = FIELD_W + 1;
  localparam logic [FIELD_W-1:0] BCAST_ADDR = '1;
  localparam logic [FIELD_W-1:0] ALT_MODE_SA = '1;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic startTimer;
    logic abortTimer;
  } ctlStrobe_t;

  // datapath -> control decode of the word on cmdWord
  typedef struct packed {
    logic accept;
    logic bcast;
    logic isMode;
    logic legal;
    logic needsData;
  } cmdDecode_t;

  function automatic logic modeDefined(input logic [FIELD_W-1:0] code, input logic tr);
    case (code)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8,
      5'd16, 5'd18, 5'd19: modeDefined = tr;
      5'd17, 5'd20, 5'd21: modeDefined = !tr;
      default:             modeDefined = 1'b0;
    endcase
  endfunction

  function automatic logic bcastForbidden(input logic [FIELD_W-1:0] code);
    bcastForbidden = (code == 5'd2) || (code == 5'd16) || (code == 5'd18) || (code == 5'd19);
  endfunction

endpackage

// File: rtl/rt_cmd_datapath.sv
module rt_cmd_datapath
  import rt_cmd_pkg::*;
#(
  parameter int CLK_MHZ  = 16,
  parameter int LONG_US  = 12,
  parameter int SHORT_US = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] addrPins,
  input  logic               addrParPin,
  input  logic               shortRespEn,
  input  logic [WORD_W-1:0]  cmdWord,
  input  ctlStrobe_t         ctl,
  output cmdDecode_t         dec,
  output logic [COUNT_W-1:0] dataWords,
  output logic               addrValid,
  output logic               storeReleased,
  output logic               cmdIsTx,
  output logic               cmdIsMode,
  output logic               cmdBroadcast,
  output logic [FIELD_W-1:0] cmdSubAddr,
  output logic [FIELD_W-1:0] cmdCode,
  output logic [COUNT_W-1:0] cmdWordCount,
  output logic               timerBusy,
  output logic               respStart
);

  localparam int LONG_CYC  = LONG_US * CLK_MHZ;
  localparam int SHORT_CYC = SHORT_US * CLK_MHZ;
  localparam int TMR_W     = $clog2(LONG_CYC + 1);

  logic [FIELD_W-1:0] ownAddr;
  logic               ownPar;
  logic [TMR_W-1:0]   tmrCnt;

  // address capture while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownAddr <= addrPins;
      ownPar  <= addrParPin;
    end
  end

  assign addrValid = (^{ownPar, ownAddr}) && (ownAddr != BCAST_ADDR);

  always_ff @(posedge clk) storeReleased <= &{addrParPin, addrPins};

  // field split
  logic [FIELD_W-1:0] cAddr, cSa, cCode;
  logic               cTr;
  logic [COUNT_W-1:0] cWords;
  assign cAddr = cmdWord[WORD_W-1 -: FIELD_W];
  assign cTr   = cmdWord[2*FIELD_W];
  assign cSa   = cmdWord[2*FIELD_W-1 -: FIELD_W];
  assign cCode = cmdWord[FIELD_W-1:0];
  assign cWords = (cCode == '0) ? COUNT_W'(1 << FIELD_W) : {1'b0, cCode};

  always_comb begin
    dec.bcast     = (cAddr == BCAST_ADDR);
    dec.accept    = dec.bcast || (addrValid && (cAddr == ownAddr));
    dec.isMode    = (cSa == '0) || ((cSa == ALT_MODE_SA) && !shortRespEn);
    if (dec.isMode) begin
      dec.legal     = modeDefined(cCode, cTr) && !(dec.bcast && bcastForbidden(cCode));
      dec.needsData = !cTr && cCode[FIELD_W-1];
      dataWords     = COUNT_W'(1);
    end else begin
      dec.legal     = !(dec.bcast && cTr);
      dec.needsData = !cTr;
      dataWords     = cWords;
    end
  end

  // decoded field registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdIsTx      <= 1'b0;
      cmdIsMode    <= 1'b0;
      cmdBroadcast <= 1'b0;
      cmdSubAddr   <= '0;
      cmdCode      <= '0;
      cmdWordCount <= '0;
    end else if (ctl.load) begin
      cmdIsTx      <= cTr;
      cmdIsMode    <= dec.isMode;
      cmdBroadcast <= dec.bcast;
      cmdSubAddr   <= cSa;
      cmdCode      <= cCode;
      cmdWordCount <= dec.isMode ? '0 : cWords;
    end
  end

  // response delay timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerBusy <= 1'b0;
      tmrCnt    <= '0;
      respStart <= 1'b0;
    end else begin
      respStart <= 1'b0;
      if (ctl.startTimer) begin
        timerBusy <= 1'b1;
        tmrCnt    <= shortRespEn ? TMR_W'(SHORT_CYC - 1) : TMR_W'(LONG_CYC - 1);
      end else if (ctl.abortTimer) begin
        timerBusy <= 1'b0;
      end else if (timerBusy) begin
        if (tmrCnt == '0) begin
          timerBusy <= 1'b0;
          respStart <= 1'b1;
        end else begin
          tmrCnt <= tmrCnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rt_cmd_control.sv
module rt_cmd_control
  import rt_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdStrobe,
  input  logic               dataStrobe,
  input  logic               msgRejectN,
  input  cmdDecode_t         dec,
  input  logic [COUNT_W-1:0] dataWords,
  input  logic               timerBusy,
  output ctlStrobe_t         ctl,
  output logic               cmdValid,
  output logic               headerRcvd,
  output logic               msgError
);

  typedef enum logic [1:0] {ST_IDLE, ST_RXDATA, ST_RESP} ctlState_t;

  ctlState_t          state;
  logic [COUNT_W-1:0] remain;
  logic               headerDue;
  logic               bcastMsg;
  logic               lastWord;

  assign lastWord = (state == ST_RXDATA) && dataStrobe && (remain == COUNT_W'(1));

  always_comb begin
    ctl = '0;
    if (cmdStrobe) begin
      ctl.load       = dec.accept;
      ctl.startTimer = dec.accept && !dec.needsData && !dec.bcast;
      ctl.abortTimer = !ctl.startTimer;
    end else if (lastWord && !bcastMsg) begin
      ctl.startTimer = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      remain     <= '0;
      headerDue  <= 1'b0;
      bcastMsg   <= 1'b0;
      cmdValid   <= 1'b0;
      headerRcvd <= 1'b0;
      msgError   <= 1'b0;
    end else begin
      cmdValid   <= 1'b0;
      headerRcvd <= 1'b0;
      if (cmdStrobe) begin
        if (dec.accept) begin
          cmdValid  <= 1'b1;
          msgError  <= !dec.legal || !msgRejectN;
          bcastMsg  <= dec.bcast;
          remain    <= dataWords;
          headerDue <= !dec.isMode;
          if (dec.needsData)  state <= ST_RXDATA;
          else if (dec.bcast) state <= ST_IDLE;
          else                state <= ST_RESP;
        end else begin
          state <= ST_IDLE;
        end
      end else begin
        case (state)
          ST_RXDATA: begin
            if (!msgRejectN) msgError <= 1'b1;
            if (dataStrobe) begin
              headerRcvd <= headerDue;
              headerDue  <= 1'b0;
              if (lastWord) state  <= bcastMsg ? ST_IDLE : ST_RESP;
              else          remain <= remain - 1'b1;
            end
          end
          ST_RESP: begin
            if (!msgRejectN) msgError <= 1'b1;
            if (!timerBusy) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rt_cmd_decoder.sv
module rt_cmd_decoder
  import rt_cmd_pkg::*;
#(
  parameter int CLK_MHZ  = 16,
  parameter int LONG_US  = 12,
  parameter int SHORT_US = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  addrPins,
  input  logic        addrParPin,
  input  logic        shortRespEn,
  input  logic        msgRejectN,
  input  logic        cmdStrobe,
  input  logic [15:0] cmdWord,
  input  logic        dataStrobe,
  output logic        addrValid,
  output logic        storeReleased,
  output logic        cmdValid,
  output logic        headerRcvd,
  output logic        cmdIsTx,
  output logic        cmdIsMode,
  output logic        cmdBroadcast,
  output logic [4:0]  cmdSubAddr,
  output logic [4:0]  cmdCode,
  output logic [5:0]  cmdWordCount,
  output logic        msgError,
  output logic        respStart
);

  ctlStrobe_t         ctl;
  cmdDecode_t         dec;
  logic [COUNT_W-1:0] dataWords;
  logic               timerBusy;

  rt_cmd_datapath #(
    .CLK_MHZ(CLK_MHZ), .LONG_US(LONG_US), .SHORT_US(SHORT_US)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addrPins(addrPins), .addrParPin(addrParPin),
    .shortRespEn(shortRespEn), .cmdWord(cmdWord), .ctl(ctl), .dec(dec),
    .dataWords(dataWords), .addrValid(addrValid), .storeReleased(storeReleased),
    .cmdIsTx(cmdIsTx), .cmdIsMode(cmdIsMode), .cmdBroadcast(cmdBroadcast),
    .cmdSubAddr(cmdSubAddr), .cmdCode(cmdCode), .cmdWordCount(cmdWordCount),
    .timerBusy(timerBusy), .respStart(respStart)
  );

  rt_cmd_control u_ctl (
    .clk(clk), .rstN(rstN), .cmdStrobe(cmdStrobe), .dataStrobe(dataStrobe),
    .msgRejectN(msgRejectN), .dec(dec), .dataWords(dataWords),
    .timerBusy(timerBusy), .ctl(ctl), .cmdValid(cmdValid),
    .headerRcvd(headerRcvd), .msgError(msgError)
  );

endmodule

// File: rtl/rt_cmd_decoder_chk.sv
module rt_cmd_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic [4:0]  addrPins,
  input logic        addrParPin,
  input logic        shortRespEn,
  input logic        cmdStrobe,
  input logic        dataStrobe,
  input logic        addrValid,
  input logic        storeReleased,
  input logic        cmdValid,
  input logic        headerRcvd,
  input logic        cmdIsMode,
  input logic        cmdBroadcast,
  input logic [4:0]  cmdSubAddr,
  input logic        respStart
);

  AST_OWN_ADDR_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdBroadcast |-> addrValid); // R2

  AST_STREL_FROM_PINS: assert property (@(posedge clk) disable iff (!rstN)
    storeReleased |-> $past(&{addrParPin, addrPins})); // R3

  AST_SA31_MODE_SEL: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdSubAddr == 5'd31) |-> (cmdIsMode == !$past(shortRespEn))); // R5

  AST_CMDVALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(cmdStrobe)); // R9

  AST_HEADER_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    headerRcvd |-> $past(dataStrobe)); // R10

  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    respStart |=> !respStart); // R11

  AST_BCAST_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    respStart |-> !cmdBroadcast); // R12

endmodule

bind rt_cmd_decoder rt_cmd_decoder_chk u_chk (.*);

// File: tb/rt_cmd_decoder_test.sv
module rt_cmd_decoder_test;

  localparam int LONG_D  = 192;
  localparam int SHORT_D = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  addrPins = 5'd5;
  logic        addrParPin = 1'b1;
  logic        shortRespEn = 1'b0;
  logic        msgRejectN = 1'b1;
  logic        cmdStrobe = 1'b0;
  logic [15:0] cmdWord = '0;
  logic        dataStrobe = 1'b0;
  logic        addrValid, storeReleased, cmdValid, headerRcvd;
  logic        cmdIsTx, cmdIsMode, cmdBroadcast, msgError, respStart;
  logic [4:0]  cmdSubAddr, cmdCode;
  logic [5:0]  cmdWordCount;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rt_cmd_decoder uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic doReset(input logic [4:0] a, input logic p);
    @(negedge clk);
    rstN = 1'b0; addrPins = a; addrParPin = p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendCmd(input int a, input int tr, input int sa, input int code);
    @(negedge clk);
    cmdWord = {a[4:0], tr[0], sa[4:0], code[4:0]};
    cmdStrobe = 1'b1;
    @(negedge clk);
    cmdStrobe = 1'b0;
  endtask

  task automatic sendData();
    @(negedge clk);
    dataStrobe = 1'b1;
    @(negedge clk);
    dataStrobe = 1'b0;
  endtask

  task automatic expectResp(input int d, input string req);
    int early = 0;
    for (int k = 1; k < d; k++) begin
      @(negedge clk);
      if (respStart) early++;
    end
    eq({req, " no early reply"}, early, 0);
    @(negedge clk);
    eq({req, " reply at delay"}, respStart, 1);
  endtask

  task automatic expectNoResp(input int n, input string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (respStart) seen++;
    end
    eq(req, seen, 0);
  endtask

  task automatic t_reset();
    eq("R1 addrValid after reset", addrValid, 1);
    eq("R3 storeReleased low", storeReleased, 0);
    eq("R9 cmdValid idle", cmdValid, 0);
    eq("R11 respStart idle", respStart, 0);
    eq("R8 msgError idle", msgError, 0);
  endtask

  task automatic t_transmit();
    sendCmd(5, 1, 3, 4);
    eq("R9 cmdValid pulse", cmdValid, 1);
    eq("R5 isTx", cmdIsTx, 1);
    eq("R5 not mode", cmdIsMode, 0);
    eq("R5 subaddr", cmdSubAddr, 3);
    eq("R6 word count", cmdWordCount, 4);
    eq("R7 legal tx", msgError, 0);
    expectResp(LONG_D, "R11 long tx");
  endtask

  task automatic t_receive32();
    sendCmd(5, 0, 7, 0);
    eq("R6 count 0 means 32", cmdWordCount, 32);
    eq("R5 rx", cmdIsTx, 0);
    for (int i = 0; i < 32; i++) begin
      sendData();
      eq("R10 header only on first word", headerRcvd, (i == 0) ? 1 : 0);
      if (i < 31) eq("R6 no reply before last word", respStart, 0);
    end
    expectResp(LONG_D, "R11 rx after last word");
  endtask

  task automatic t_shortSa31();
    shortRespEn = 1'b1;
    sendCmd(5, 0, 31, 2);
    eq("R5 sa31 data when short", cmdIsMode, 0);
    eq("R6 count 2", cmdWordCount, 2);
    sendData();
    eq("R10 header sa31", headerRcvd, 1);
    sendData();
    expectResp(SHORT_D, "R11 short delay");
    shortRespEn = 1'b0;
  endtask

  task automatic t_modeSa31();
    sendCmd(5, 1, 31, 18);
    eq("R5 sa31 mode when long", cmdIsMode, 1);
    eq("R5 mode code field", cmdCode, 18);
    eq("R7 code 18 legal", msgError, 0);
    expectResp(LONG_D, "R11 mode reply");
  endtask

  task automatic t_illegalMode();
    sendCmd(5, 1, 0, 9);
    eq("R7 code 9 illegal", msgError, 1);
    expectResp(LONG_D, "R7 illegal still replies");
    sendCmd(5, 0, 0, 2);
    eq("R7 code 2 with T/R=0 illegal", msgError, 1);
    expectResp(LONG_D, "R7 illegal reply 2");
  endtask

  task automatic t_modeData();
    sendCmd(5, 0, 0, 17);
    eq("R7 code 17 rx legal", msgError, 0);
    eq("R5 mode sa0", cmdIsMode, 1);
    eq("R6 mode count shows 0", cmdWordCount, 0);
    sendData();
    eq("R10 no header on mode data", headerRcvd, 0);
    expectResp(LONG_D, "R6 mode data word then reply");
  endtask

  task automatic t_reject();
    msgRejectN = 1'b0;
    sendCmd(5, 1, 4, 1);
    msgRejectN = 1'b1;
    eq("R8 reject at command", msgError, 1);
    expectResp(LONG_D, "R8 rejected still replies");
    sendCmd(5, 1, 4, 1);
    eq("R8 cleared by next command", msgError, 0);
    expectResp(LONG_D, "R8 clean reply");
    sendCmd(5, 0, 4, 2);
    eq("R8 clean rx start", msgError, 0);
    @(negedge clk) msgRejectN = 1'b0;
    @(negedge clk) msgRejectN = 1'b1;
    sendData();
    sendData();
    eq("R8 reject mid message", msgError, 1);
    expectResp(LONG_D, "R8 mid reject reply");
  endtask

  task automatic t_otherAddr();
    sendCmd(6, 1, 9, 3);
    eq("R4 other address no cmdValid", cmdValid, 0);
    eq("R4 fields unchanged", cmdSubAddr, 4);
    expectNoResp(LONG_D + 8, "R4 other address no reply");
  endtask

  task automatic t_broadcast();
    sendCmd(5, 1, 3, 1);
    repeat (20) @(negedge clk);
    sendCmd(31, 0, 2, 1);
    eq("R4 broadcast accepted", cmdValid, 1);
    eq("R4 broadcast flag", cmdBroadcast, 1);
    eq("R7 broadcast rx legal", msgError, 0);
    sendData();
    eq("R10 broadcast header", headerRcvd, 1);
    expectNoResp(LONG_D + 40, "R12 broadcast silent and cancels pending");
    sendCmd(31, 1, 0, 2);
    eq("R7 broadcast code 2 illegal", msgError, 1);
    sendCmd(31, 1, 5, 1);
    eq("R7 broadcast transmit illegal", msgError, 1);
    expectNoResp(LONG_D + 8, "R12 broadcast no reply");
  endtask

  task automatic t_latch();
    @(negedge clk);
    addrPins = 5'd9; addrParPin = 1'b1;
    sendCmd(9, 1, 3, 1);
    eq("R1 new pins ignored", cmdValid, 0);
    sendCmd(5, 1, 3, 1);
    eq("R1 latched address kept", cmdValid, 1);
    expectResp(LONG_D, "R1 reply");
  endtask

  task automatic t_evenParity();
    doReset(5'd5, 1'b0);
    @(negedge clk);
    eq("R2 even parity invalid", addrValid, 0);
    sendCmd(5, 1, 3, 1);
    eq("R2 no accept on even parity", cmdValid, 0);
    expectNoResp(LONG_D + 8, "R2 no reply");
  endtask

  task automatic t_open();
    doReset(5'd31, 1'b1);
    @(negedge clk);
    eq("R3 storeReleased on open pins", storeReleased, 1);
    eq("R2 address 31 invalid", addrValid, 0);
    addrPins = 5'd5;
    @(negedge clk);
    @(negedge clk);
    eq("R3 storeReleased drops", storeReleased, 0);
    eq("R1 latch unchanged by pins", addrValid, 0);
  endtask

  initial begin
    doReset(5'd5, 1'b1);
    @(negedge clk);
    t_reset();
    t_transmit();
    t_receive32();
    t_shortSa31();
    t_modeSa31();
    t_illegalMode();
    t_modeData();
    t_reject();
    t_otherAddr();
    t_broadcast();
    t_latch();
    t_evenParity();
    t_open();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1500000;
    vectors++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule